// File: doc/BRIEF.md
# Pipelined Byte-Writable Synchronous Memory Core

This block is the storage and data path of a synchronous burst memory that is four byte lanes wide. An external burst sequencer gives it one word address per clock. The sequencer also reports whether the device is selected on that edge and whether the edge opens a new cycle. A cycle can be opened through the processor-side start input or through the controller-side start input. On every selected edge the core decides between a read and a write. It makes that decision from a global write enable, a byte-write master enable and four per-lane write enables. For a cycle opened from the processor side, the write controls are not looked at on the opening edge.

Reads go through two registers. The word is captured into an internal data register on the edge that samples the address. It moves into the output register on the next edge. Writes capture their data and lane mask on the edge that samples them. They are held in a posted-write register and reach the array on the following edge. A read on that following edge merges the posted bytes into the word it returns, so data written on one edge can be read back on the very next edge. The data bus is split into `data_in`, `data_out` and a drive enable `data_oe`. The output enable input gates `data_oe` without passing through any register.

Top module: `burst_sram_core`

## Requirements
- R1: A read sampled on rising edge k shows the addressed word on `data_out`, with `data_oe` high, after edge k+1, provided `oe_n` is low and edge k+1 samples no write.
- R2: On a selected edge that is not a processor start, `gw_n` low writes all four lanes, whatever `bwe_n` and `lane_we_n` are.
- R3: With `gw_n` high and `bwe_n` low, each lane whose `lane_we_n` bit is low is written and the other lanes keep their contents. Bit i selects lane i, which is bits 8i+7:8i.
- R4: With `gw_n` high and either `bwe_n` high or all `lane_we_n` bits high, a selected edge is a read and changes no stored byte.
- R5: On an edge where `start_proc` is high, every write control is ignored and the edge is a read. `start_proc` takes priority over `start_ctrl`.
- R6: On an edge where `start_ctrl` is high and `start_proc` is low, the write controls are sampled on that same edge.
- R7: After any edge that samples a write, `data_oe` is low whatever `oe_n` is, even if a read sampled on the edge before was still in flight.
- R8: While `oe_n` is high, `data_oe` is low. It follows `oe_n` without waiting for a clock edge.
- R9: A read on the edge right after a write to the same address returns the newly written bytes in the written lanes and the earlier contents in the other lanes.
- R10: An edge with `sel` low starts no access, and `data_oe` is low after the edge that follows it.
- R11: While `rst_n` is low, `data_oe` is low and no posted write is pending.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| rst_n | input | 1 | Active-low synchronous reset of the control state |
| sel | input | 1 | Device selected and an access takes place on this edge |
| start_proc | input | 1 | Edge opens a cycle from the processor side (write controls ignored) |
| start_ctrl | input | 1 | Edge opens a cycle from the controller side (write controls sampled) |
| addr | input | AW | Word address supplied by the burst sequencer |
| gw_n | input | 1 | Global write, active low, writes every lane |
| bwe_n | input | 1 | Byte-write master enable, active low |
| lane_we_n | input | LANES | Per-lane write enables, active low |
| oe_n | input | 1 | Output enable, active low, not registered |
| data_in | input | LANES*LANE_W | Write data |
| data_out | output | LANES*LANE_W | Output register contents |
| data_oe | output | 1 | Drive enable for the data bus |

## Verification
The checker looks at every clock. It confirms that `data_oe` is never high while `oe_n` is high, and never on the edge after a sampled write or one edge after a deselected edge. It also confirms that the drivers are only ever enabled by a read sampled two edges earlier. Those rules cover the output-control side of R7, R8, R10 and R11. The stored contents can only be seen through the bench's scenarios: lane masking under the three write-enable levels and the start-edge sampling difference (R2 to R6). The same holds for the merge of a posted write into the read on the very next edge (R9) and the exact word that arrives after two registers (R1).

// File: rtl/sram_core_pkg.sv
package sram_core_pkg;
   // Kind of edge as seen by the write-enable decoder
   typedef enum logic [1:0] {
      EDGE_CONT  = 2'd0,
      EDGE_PROC  = 2'd1,
      EDGE_CTRL  = 2'd2,
      EDGE_IDLE  = 2'd3
   } edge_kind_e;

   // Operation chosen for one sampled edge
   typedef enum logic [1:0] {
      OP_NONE  = 2'd0,
      OP_READ  = 2'd1,
      OP_WRITE = 2'd2
   } edge_op_e;

   function automatic edge_kind_e classify_edge(input logic sel_i,
                                                input logic sp_i,
                                                input logic sc_i);
      edge_kind_e k;
      if (!sel_i)    k = EDGE_IDLE;
      else if (sp_i) k = EDGE_PROC;
      else if (sc_i) k = EDGE_CTRL;
      else           k = EDGE_CONT;
      return k;
   endfunction
endpackage

// File: rtl/sram_wen_decode.sv
module sram_wen_decode
   import sram_core_pkg::*;
#(
   parameter int LANES = 4
)(
   input  edge_kind_e       kind,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_we_n,
   output edge_op_e         op,
   output logic [LANES-1:0] lane_mask
);
   logic [LANES-1:0] raw_mask;
   logic             ctl_live;

   // Write controls are ignored only on a processor-opened edge
   assign ctl_live = (kind == EDGE_CONT) || (kind == EDGE_CTRL);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_lane
         // global write overrides; else master enable gates per-lane enable
         always_comb begin
            if (!gw_n)      raw_mask[g] = 1'b1;
            else if (!bwe_n) raw_mask[g] = ~lane_we_n[g];
            else             raw_mask[g] = 1'b0;
         end
      end
   endgenerate

   always_comb begin
      if (kind == EDGE_IDLE) begin
         op        = OP_NONE;
         lane_mask = '0;
      end else if (ctl_live && (|raw_mask)) begin
         op        = OP_WRITE;
         lane_mask = raw_mask;
      end else begin
         op        = OP_READ;
         lane_mask = '0;
      end
   end
endmodule

// File: rtl/sram_post_write.sv
module sram_post_write #(
   parameter int AW     = 5,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int DW    = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             wr_now,
   input  logic [AW-1:0]    wr_addr,
   input  logic [LANES-1:0] wr_mask,
   input  logic [DW-1:0]    wr_data,
   input  logic [AW-1:0]    rd_addr,
   input  logic [DW-1:0]    arr_word,
   output logic             cm_en,
   output logic [AW-1:0]    cm_addr,
   output logic [LANES-1:0] cm_mask,
   output logic [DW-1:0]    cm_data,
   output logic [DW-1:0]    merged_word
);
   logic             pend_q;
   logic [AW-1:0]    addr_q;
   logic [LANES-1:0] mask_q;
   logic [DW-1:0]    data_q;
   logic             hit;

   always_ff @(posedge clk) begin
      if (!rst_n) pend_q <= 1'b0;
      else        pend_q <= wr_now;
   end

   always_ff @(posedge clk) begin
      if (wr_now) begin
         addr_q <= wr_addr;
         mask_q <= wr_mask;
         data_q <= wr_data;
      end
   end

   assign cm_en   = pend_q;
   assign cm_addr = addr_q;
   assign cm_mask = mask_q;
   assign cm_data = data_q;
   assign hit     = pend_q && (addr_q == rd_addr);

   generate
      for (genvar g = 0; g < LANES; g++) begin : g_fwd
         assign merged_word[g*LANE_W +: LANE_W] =
            (hit && mask_q[g]) ? data_q[g*LANE_W +: LANE_W]
                               : arr_word[g*LANE_W +: LANE_W];
      end
   endgenerate
endmodule

// File: rtl/sram_byte_array.sv
module sram_byte_array #(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             we,
   input  logic [AW-1:0]    waddr,
   input  logic [LANES-1:0] wmask,
   input  logic [DW-1:0]    wdata,
   input  logic [AW-1:0]    raddr,
   output logic [DW-1:0]    rword
);
   generate
      for (genvar g = 0; g < LANES; g++) begin : g_bank
         logic [LANE_W-1:0] cells [DEPTH];
         always_ff @(posedge clk) begin
            if (we && wmask[g]) cells[waddr] <= wdata[g*LANE_W +: LANE_W];
         end
         assign rword[g*LANE_W +: LANE_W] = cells[raddr];
      end
   endgenerate
endmodule

// File: rtl/sram_out_pipe.sv
module sram_out_pipe #(
   parameter int DW = 32
)(
   input  logic          clk,
   input  logic          rst_n,
   input  logic          rd_now,
   input  logic          wr_now,
   input  logic [DW-1:0] rd_word,
   output logic [DW-1:0] q_word,
   output logic          q_live
);
   logic [DW-1:0] stage_d;
   logic          stage_v;

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         stage_v <= 1'b0;
         q_live  <= 1'b0;
      end else begin
         stage_v <= rd_now;
         // a write sampled on this edge turns the drivers off
         q_live  <= stage_v && !wr_now;
      end
   end

   always_ff @(posedge clk) begin
      if (rd_now) stage_d <= rd_word;
      q_word <= stage_d;
   end
endmodule

// File: rtl/burst_sram_core.sv
module burst_sram_core
   import sram_core_pkg::*;
#(
   parameter int DEPTH  = 64,
   parameter int LANES  = 4,
   parameter int LANE_W = 8,
   localparam int AW    = $clog2(DEPTH),
   localparam int DW    = LANES * LANE_W
)(
   input  logic             clk,
   input  logic             rst_n,
   input  logic             sel,
   input  logic             start_proc,
   input  logic             start_ctrl,
   input  logic [AW-1:0]    addr,
   input  logic             gw_n,
   input  logic             bwe_n,
   input  logic [LANES-1:0] lane_we_n,
   input  logic             oe_n,
   input  logic [DW-1:0]    data_in,
   output logic [DW-1:0]    data_out,
   output logic             data_oe
);
   generate
      if (DEPTH < 2) begin : g_bad_depth
         $error("burst_sram_core: DEPTH must be at least 2");
      end
      if ((1 << AW) != DEPTH) begin : g_bad_pow2
         $error("burst_sram_core: DEPTH must be a power of two");
      end
      if (LANES < 1 || LANE_W < 1) begin : g_bad_lane
         $error("burst_sram_core: LANES and LANE_W must be positive");
      end
   endgenerate

   edge_kind_e       kind;
   edge_op_e         op;
   logic [LANES-1:0] mask;
   logic             wr_now, rd_now;
   logic             cm_en;
   logic [AW-1:0]    cm_addr;
   logic [LANES-1:0] cm_mask;
   logic [DW-1:0]    cm_data;
   logic [DW-1:0]    arr_word, merged;
   logic             q_live;

   assign kind   = classify_edge(sel, start_proc, start_ctrl);
   assign wr_now = (op == OP_WRITE);
   assign rd_now = (op == OP_READ);

   sram_wen_decode #(.LANES(LANES)) u_dec (
      .kind      (kind),
      .gw_n      (gw_n),
      .bwe_n     (bwe_n),
      .lane_we_n (lane_we_n),
      .op        (op),
      .lane_mask (mask)
   );

   sram_post_write #(.AW(AW), .LANES(LANES), .LANE_W(LANE_W)) u_post (
      .clk         (clk),
      .rst_n       (rst_n),
      .wr_now      (wr_now),
      .wr_addr     (addr),
      .wr_mask     (mask),
      .wr_data     (data_in),
      .rd_addr     (addr),
      .arr_word    (arr_word),
      .cm_en       (cm_en),
      .cm_addr     (cm_addr),
      .cm_mask     (cm_mask),
      .cm_data     (cm_data),
      .merged_word (merged)
   );

   sram_byte_array #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LANE_W)) u_arr (
      .clk   (clk),
      .we    (cm_en),
      .waddr (cm_addr),
      .wmask (cm_mask),
      .wdata (cm_data),
      .raddr (addr),
      .rword (arr_word)
   );

   sram_out_pipe #(.DW(DW)) u_pipe (
      .clk     (clk),
      .rst_n   (rst_n),
      .rd_now  (rd_now),
      .wr_now  (wr_now),
      .rd_word (merged),
      .q_word  (data_out),
      .q_live  (q_live)
   );

   // output enable acts without a register
   assign data_oe = q_live && !oe_n;
endmodule

// File: rtl/burst_sram_core_chk.sv
module burst_sram_core_chk #(
   parameter int LANES = 4
)(
   input logic             clk,
   input logic             rst_n,
   input logic             sel,
   input logic             start_proc,
   input logic             gw_n,
   input logic             bwe_n,
   input logic [LANES-1:0] lane_we_n,
   input logic             oe_n,
   input logic             data_oe
);
   logic port_wr, port_rd;
   assign port_wr = sel && !start_proc &&
                    (!gw_n || (!bwe_n && (lane_we_n != {LANES{1'b1}})));
   assign port_rd = sel && !port_wr;

   // R8
   oe_gate_chk: assert property (@(posedge clk) oe_n |-> !data_oe);

   // R7
   wr_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr |=> !data_oe);

   // R10
   desel_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !sel |=> ##1 !data_oe);

   // R1
   rd_src_chk: assert property (@(posedge clk) disable iff (!rst_n)
      data_oe |-> $past(port_rd, 2));

   // R11
   rst_quiet_chk: assert property (@(posedge clk)
      $past(!rst_n) |-> !data_oe);
endmodule

bind burst_sram_core burst_sram_core_chk #(.LANES(LANES)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .sel        (sel),
   .start_proc (start_proc),
   .gw_n       (gw_n),
   .bwe_n      (bwe_n),
   .lane_we_n  (lane_we_n),
   .oe_n       (oe_n),
   .data_oe    (data_oe)
);

// File: tb/tb_burst_sram_core.sv
module tb_burst_sram_core;
   localparam int DEPTH = 64;
   localparam int LANES = 4;
   localparam int LW    = 8;
   localparam int AW    = $clog2(DEPTH);
   localparam int DW    = LANES * LW;

   logic             clk = 1'b0;
   logic             rst_n = 1'b0;
   logic             sel = 1'b0, start_proc = 1'b0, start_ctrl = 1'b0;
   logic [AW-1:0]    addr = '0;
   logic             gw_n = 1'b1, bwe_n = 1'b1, oe_n = 1'b0;
   logic [LANES-1:0] lane_we_n = '1;
   logic [DW-1:0]    data_in = '0;
   logic [DW-1:0]    data_out;
   logic             data_oe;

   int vectors = 0;
   int misses  = 0;
   bit done    = 1'b0;

   // reference state
   logic [DW-1:0] ref_mem [DEPTH];
   logic [DW-1:0] ref_s1d, ref_out;
   logic          ref_s1v = 1'b0, ref_en = 1'b0;

   always #2 clk = ~clk;

   burst_sram_core #(.DEPTH(DEPTH), .LANES(LANES), .LANE_W(LW)) dut (
      .clk(clk), .rst_n(rst_n), .sel(sel), .start_proc(start_proc),
      .start_ctrl(start_ctrl), .addr(addr), .gw_n(gw_n), .bwe_n(bwe_n),
      .lane_we_n(lane_we_n), .oe_n(oe_n), .data_in(data_in),
      .data_out(data_out), .data_oe(data_oe));

   function automatic logic [LANES-1:0] exp_mask(input logic sp, input logic g,
                                                 input logic b,
                                                 input logic [LANES-1:0] w);
      if (sp)     return '0;
      if (!g)     return '1;
      if (!b)     return ~w;
      return '0;
   endfunction

   function automatic logic [DW-1:0] apply_lanes(input logic [DW-1:0] old_w,
                                                 input logic [DW-1:0] new_w,
                                                 input logic [LANES-1:0] m);
      logic [DW-1:0] r = old_w;
      for (int i = 0; i < LANES; i++)
         if (m[i]) r[i*LW +: LW] = new_w[i*LW +: LW];
      return r;
   endfunction

   task automatic check(input string tag, input logic [DW-1:0] act,
                        input logic [DW-1:0] exp);
      vectors++;
      if (act !== exp) begin
         misses++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // one clock: drive at negedge, model the edge, check after the edge
   task automatic cyc(input string tag, input logic s, input logic sp,
                      input logic sc, input logic [AW-1:0] a, input logic g,
                      input logic b, input logic [LANES-1:0] w,
                      input logic [DW-1:0] d, input logic oe);
      logic [LANES-1:0] m;
      logic wr, rd;
      @(negedge clk);
      sel = s; start_proc = sp; start_ctrl = sc; addr = a;
      gw_n = g; bwe_n = b; lane_we_n = w; data_in = d; oe_n = oe;
      m  = s ? exp_mask(sp, g, b, w) : '0;
      wr = |m;
      rd = s && !wr;
      ref_en  = ref_s1v && !wr;
      ref_out = ref_s1d;
      if (rd) ref_s1d = ref_mem[a];
      ref_s1v = rd;
      if (wr) ref_mem[a] = apply_lanes(ref_mem[a], d, m);
      @(posedge clk);
      #1;
      check({tag, " oe"}, {{(DW-1){1'b0}}, data_oe},
            {{(DW-1){1'b0}}, ref_en && !oe});
      if (ref_en && !oe) check({tag, " data"}, data_out, ref_out);
   endtask

   task automatic rd_cyc(input string tag, input logic [AW-1:0] a);
      cyc(tag, 1'b1, 1'b0, 1'b0, a, 1'b1, 1'b1, '1, '0, 1'b0);
   endtask

   task automatic idle(input string tag);
      cyc(tag, 1'b0, 1'b0, 1'b0, '0, 1'b1, 1'b1, '1, '0, 1'b0);
   endtask

   initial begin : watchdog
      #800000;
      if (!done) begin
         misses++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
         $finish;
      end
   end

   initial begin : stim
      void'($urandom(32'd20240611));
      repeat (3) @(posedge clk);
      #1;
      // R11: reset keeps drivers off
      check("R11 reset", {{(DW-1){1'b0}}, data_oe}, '0);
      @(negedge clk);
      rst_n = 1'b1;

      // R2: fill via global write, byte enables set to read to prove override
      for (int i = 0; i < DEPTH; i++)
         cyc("R2", 1'b1, 1'b0, 1'b0, AW'(i), 1'b0, 1'b1, '1,
             {8'(i), 8'(i ^ 8'h5A), 8'(~i), 8'(i + 3)}, 1'b0);
      // R1: back-to-back reads
      for (int i = 0; i < 8; i++) rd_cyc("R1", AW'(i));
      idle("R10"); idle("R10");

      // R3: lanes 0 and 2 only
      cyc("R3", 1'b1, 1'b0, 1'b1, 6'd5, 1'b1, 1'b0, 4'b1010, 32'hAABBCCDD, 1'b0);
      // R9: read right after write merges written lanes
      cyc("R9", 1'b1, 1'b0, 1'b1, 6'd5, 1'b1, 1'b1, '1, '0, 1'b0);
      rd_cyc("R9", 6'd5);
      idle("R3"); idle("R3");

      // R4: master high, lanes low -> read, nothing stored
      cyc("R4", 1'b1, 1'b0, 1'b1, 6'd9, 1'b1, 1'b1, 4'b0000, 32'h11111111, 1'b0);
      cyc("R4", 1'b1, 1'b0, 1'b0, 6'd9, 1'b1, 1'b0, 4'b1111, 32'h22222222, 1'b0);
      rd_cyc("R4", 6'd9); idle("R4"); idle("R4");

      // R5: processor start ignores global write
      cyc("R5", 1'b1, 1'b1, 1'b1, 6'd12, 1'b0, 1'b0, 4'b0000, 32'hDEADBEEF, 1'b0);
      rd_cyc("R5", 6'd12); idle("R5"); idle("R5");

      // R6: controller start writes on its own edge
      cyc("R6", 1'b1, 1'b0, 1'b1, 6'd13, 1'b0, 1'b1, '1, 32'h0BADF00D, 1'b0);
      rd_cyc("R6", 6'd13); idle("R6"); idle("R6");

      // R7: read then write: drivers off though oe_n low
      rd_cyc("R7", 6'd20);
      cyc("R7", 1'b1, 1'b0, 1'b0, 6'd21, 1'b0, 1'b1, '1, 32'hC0FFEE00, 1'b0);
      rd_cyc("R7", 6'd21); idle("R7"); idle("R7");

      // R8: oe_n high gates output at once, mid-cycle
      rd_cyc("R8", 6'd3);
      rd_cyc("R8", 6'd4);
      @(negedge clk);
      oe_n = 1'b1; #0.5;
      check("R8 async", {{(DW-1){1'b0}}, data_oe}, '0);
      oe_n = 1'b0; #0.5;
      check("R8 release", {{(DW-1){1'b0}}, data_oe}, {{(DW-1){1'b0}}, 1'b1});
      idle("R8"); idle("R8");

      // random mix
      for (int n = 0; n < 3000; n++) begin
         logic s, sp, sc, g, b, oe;
         logic [LANES-1:0] w;
         s  = ($urandom % 8) != 0;
         sp = ($urandom % 5) == 0;
         sc = ($urandom % 4) == 0;
         g  = ($urandom % 4) != 0;
         b  = ($urandom % 2) != 0;
         w  = LANES'($urandom);
         oe = ($urandom % 6) == 0;
         cyc(!g ? "R2" : (!b ? "R3" : "R1"), s, sp, sc, AW'($urandom % 8),
             g, b, w, $urandom, oe);
      end

      done = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
   end
endmodule